// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional Access

This block guards a small shared word memory for up to four requesting cores and gives them an atomic read-modify-write primitive. A core reads a word with a linked load, which also records that core's reservation on the line holding the word. Later it attempts a conditional store. The store lands only if no other core has written anywhere in that line in the meantime. A status bit tells software whether to retry its loop.

Conflicts are tracked per line, not per word. A write by another core to a neighbouring word therefore breaks a reservation even when the target word itself never changed. Such spurious failures are expected, and software handles them by looping. The conditional store compares no data. Its only condition is whether the reservation survived.

A fixed-priority arbiter accepts one request per cycle, and the lowest core index wins. A core whose request is not granted keeps it asserted until its grant bit goes high. Every granted request gets exactly one response in the following cycle, tagged with the core index. The response carries the word's contents from before the operation and a status bit.

Top module: `llsc_monitor`

## Requirements
- R1: A linked load (op code 2'b10) returns the addressed word on `rsp_rdata` one cycle after its grant, with `rsp_status` 0, and records a reservation for the requesting core on the line `addr[ADDR_W-1:2]` (4 words per line).
- R2: An ordinary load (op 2'b00) returns the addressed word. An ordinary store (op 2'b01) writes `wdata` and returns the word's previous contents. Both report status 0.
- R3: A conditional store (op 2'b11) whose core holds a reservation on the target line writes `wdata`, returns the previous contents and reports status 0.
- R4: A conditional store without a matching reservation leaves memory unchanged and reports status 1.
- R5: Any write by another core to any word of a reserved line clears that reservation, so the holder's next conditional store to the line fails.
- R6: A write by another core to a different line leaves a reservation intact.
- R7: An ordinary store by the reservation holder itself does not clear its own reservation.
- R8: Each core holds at most one reservation. A new linked load replaces the previous reservation, so a conditional store to the earlier line fails and one to the newer line succeeds.
- R9: A conditional store consumes its core's reservation whether it succeeds or fails, so a second conditional store with no linked load in between fails.
- R10: A successful conditional store counts as a write and clears every other core's reservation on the same line.
- R11: With several requests valid at once, only the lowest-index core is granted (`req_grant` one-hot). It alone is performed that cycle, and `rsp_core` names it in the response.
- R12: After reset, memory reads as zero, no reservation exists (a conditional store fails), and `rsp_valid` and `req_grant` are 0 while no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Request present, one bit per core |
| req_op | input | 2*NUM_CORES | Op code per core: 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr | input | ADDR_W*NUM_CORES | Word address per core |
| req_wdata | input | DATA_W*NUM_CORES | Write data per core |
| req_grant | output | NUM_CORES | Request accepted this cycle (combinational) |
| rsp_valid | output | 1 | Response present |
| rsp_core | output | IDX_W | Index of the core being answered |
| rsp_rdata | output | DATA_W | Word contents before the operation |
| rsp_status | output | 1 | 0 = success, 1 = conditional store failed |

## Verification
A store from one core and a conditional store from another can arrive in the same cycle, with the store aimed at a different word of the line the other core has reserved. The bench provokes this by first taking a linked load on core 1, then raising a store on core 0 and a conditional store on core 1 together. It judges the grant vector before the edge and the order of the two responses after it. It then expects the delayed conditional store to fail and a final load to show the word untouched.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } op_e;

  localparam int OP_W = 2;

  localparam logic ST_OK   = 1'b0;
  localparam logic ST_FAIL = 1'b1;

  // a memory write happens for plain stores and for conditional stores that hold
  function automatic logic op_writes(op_e op, logic cond_ok);
    return (op == OP_STORE) || ((op == OP_SC) && cond_ok);
  endfunction

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_valid,
  output logic [N-1:0]     grant,
  output logic             gnt_any,
  output logic [IDX_W-1:0] gnt_idx
);

  always_comb begin
    grant   = '0;
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_valid[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        gnt_any  = 1'b1;
        gnt_idx  = IDX_W'(i);
      end
    end
  end

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R11
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);

endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words_q [DEPTH];

  assign rdata = words_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
    end else if (we) begin
      words_q[addr] <= wdata;
    end
  end

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int N          = 4,
  parameter int ADDR_W     = 6,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [IDX_W-1:0]  core,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  output logic              cond_ok,
  output logic              wr_fire
);

  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int LINE_W = ADDR_W - OFF_W;

  function automatic logic [LINE_W-1:0] line_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  logic [N-1:0]      res_v_q;
  logic [LINE_W-1:0] res_line_q [N];
  logic [LINE_W-1:0] req_line;

  assign req_line = line_of(addr);
  assign cond_ok  = res_v_q[core] && (res_line_q[core] == req_line);
  assign wr_fire  = fire && op_writes(op, cond_ok);

  for (genvar k = 0; k < N; k++) begin : g_entry
    logic is_self;
    logic hit_line;
    logic foreign_kill;

    assign is_self      = (core == IDX_W'(k));
    assign hit_line     = res_v_q[k] && (res_line_q[k] == req_line);
    assign foreign_kill = wr_fire && !is_self && hit_line;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_v_q[k]    <= 1'b0;
        res_line_q[k] <= '0;
      end else if (fire && is_self && op == OP_LL) begin
        res_v_q[k]    <= 1'b1;
        res_line_q[k] <= req_line;
      end else if (fire && is_self && op == OP_SC) begin
        res_v_q[k]    <= 1'b0;
      end else if (foreign_kill) begin
        res_v_q[k]    <= 1'b0;
      end
    end

    // R5
    foreign_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      foreign_kill |=> !res_v_q[k]);

    // R9
    sc_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && is_self && op == OP_SC) |=> !res_v_q[k]);
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        req_valid,
  input  logic [NUM_CORES*OP_W-1:0]   req_op,
  input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
  input  logic [NUM_CORES*DATA_W-1:0] req_wdata,
  output logic [NUM_CORES-1:0]        req_grant,
  output logic                        rsp_valid,
  output logic [IDX_W-1:0]            rsp_core,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic                        rsp_status
);

  logic              gnt_any;
  logic [IDX_W-1:0]  gnt_idx;
  op_e               sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              cond_ok;
  logic              wr_fire;
  logic [DATA_W-1:0] mem_rdata;

  llsc_arbiter #(.N(NUM_CORES), .IDX_W(IDX_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .grant     (req_grant),
    .gnt_any   (gnt_any),
    .gnt_idx   (gnt_idx)
  );

  always_comb begin
    sel_op    = op_e'(req_op[int'(gnt_idx)*OP_W +: OP_W]);
    sel_addr  = req_addr[int'(gnt_idx)*ADDR_W +: ADDR_W];
    sel_wdata = req_wdata[int'(gnt_idx)*DATA_W +: DATA_W];
  end

  llsc_resv_table #(
    .N(NUM_CORES), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .IDX_W(IDX_W)
  ) u_resv (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (gnt_any),
    .core    (gnt_idx),
    .op      (sel_op),
    .addr    (sel_addr),
    .cond_ok (cond_ok),
    .wr_fire (wr_fire)
  );

  llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_core   <= '0;
      rsp_rdata  <= '0;
      rsp_status <= ST_OK;
    end else begin
      rsp_valid  <= gnt_any;
      rsp_core   <= gnt_idx;
      rsp_rdata  <= mem_rdata;
      rsp_status <= (gnt_any && sel_op == OP_SC && !cond_ok) ? ST_FAIL : ST_OK;
    end
  end

  // R11
  rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(gnt_any));

  // R4
  fail_only_on_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_FAIL) |-> ($past(sel_op) == OP_SC && !$past(wr_fire)));

endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;

  localparam int NC = 4;
  localparam int AW = 6;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC-1:0]   req_valid = '0;
  logic [NC*2-1:0] req_op = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC*DW-1:0] req_wdata = '0;
  logic [NC-1:0]   req_grant;
  logic            rsp_valid;
  logic [1:0]      rsp_core;
  logic [DW-1:0]   rsp_rdata;
  logic            rsp_status;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  llsc_monitor uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_rdata(rsp_rdata),
    .rsp_status(rsp_status)
  );

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  typedef struct packed {
    logic [1:0]  core;
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        st;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{2'd0, ST, 6'd5,  32'hAAAA0001, 32'h0,        1'b0}, // R2 store
    '{2'd1, LD, 6'd5,  32'h0,        32'hAAAA0001, 1'b0}, // R2 load
    '{2'd0, LL, 6'd5,  32'h0,        32'hAAAA0001, 1'b0}, // R1
    '{2'd0, SC, 6'd5,  32'h11,       32'hAAAA0001, 1'b0}, // R3
    '{2'd2, LD, 6'd5,  32'h0,        32'h11,       1'b0}, // R3 write landed
    '{2'd0, SC, 6'd5,  32'h22,       32'h11,       1'b1}, // R9 second SC fails
    '{2'd2, LD, 6'd5,  32'h0,        32'h11,       1'b0}, // R4 memory kept
    '{2'd1, LL, 6'd8,  32'h0,        32'h0,        1'b0}, // R5 reserve line 2
    '{2'd2, ST, 6'd11, 32'h33,       32'h0,        1'b0}, // R5 other word, same line
    '{2'd1, SC, 6'd8,  32'h44,       32'h0,        1'b1}, // R5 spurious fail
    '{2'd1, LD, 6'd8,  32'h0,        32'h0,        1'b0}, // R4 untouched
    '{2'd1, LL, 6'd12, 32'h0,        32'h0,        1'b0}, // R6
    '{2'd3, ST, 6'd16, 32'h55,       32'h0,        1'b0}, // R6 other line
    '{2'd1, SC, 6'd12, 32'h66,       32'h0,        1'b0}, // R6 still holds
    '{2'd2, LL, 6'd20, 32'h0,        32'h0,        1'b0}, // R7
    '{2'd2, ST, 6'd21, 32'h77,       32'h0,        1'b0}, // R7 own store
    '{2'd2, SC, 6'd20, 32'h88,       32'h0,        1'b0}, // R7 still holds
    '{2'd3, LL, 6'd24, 32'h0,        32'h0,        1'b0}, // R8
    '{2'd3, LL, 6'd28, 32'h0,        32'h0,        1'b0}, // R8 replace
    '{2'd3, SC, 6'd24, 32'h99,       32'h0,        1'b1}, // R8 old line fails
    '{2'd3, LL, 6'd24, 32'h0,        32'h0,        1'b0}, // R8
    '{2'd3, LL, 6'd28, 32'h0,        32'h0,        1'b0}, // R8 replace
    '{2'd3, SC, 6'd28, 32'hAB,       32'h0,        1'b0}, // R8 new line ok
    '{2'd0, LL, 6'd32, 32'h0,        32'h0,        1'b0}, // R10
    '{2'd1, LL, 6'd33, 32'h0,        32'h0,        1'b0}, // R10
    '{2'd0, SC, 6'd32, 32'hCD,       32'h0,        1'b0}, // R10 winner
    '{2'd1, SC, 6'd33, 32'hEF,       32'h0,        1'b1}, // R10 loser
    '{2'd1, LD, 6'd33, 32'h0,        32'h0,        1'b0}  // R10 no write
  };

  task automatic set_req(int c, logic [1:0] op, logic [5:0] a, logic [31:0] wd);
    req_valid[c]         = 1'b1;
    req_op[c*2 +: 2]     = op;
    req_addr[c*AW +: AW] = a;
    req_wdata[c*DW +: DW] = wd;
  endtask

  task automatic chk_rsp(string tag, logic [1:0] c, logic [31:0] rd, logic st);
    total++;
    if (!rsp_valid || rsp_core !== c || rsp_rdata !== rd || rsp_status !== st) begin
      bad++;
      $display("FAIL %s: got v=%0b core=%0d rd=%h st=%0b, exp v=1 core=%0d rd=%h st=%0b",
               tag, rsp_valid, rsp_core, rsp_rdata, rsp_status, c, rd, st);
    end
  endtask

  task automatic chk_bits(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic one_req(string tag, logic [1:0] c, logic [1:0] op, logic [5:0] a,
                         logic [31:0] wd, logic [31:0] rd, logic st);
    @(negedge clk);
    set_req(int'(c), op, a, wd);
    @(negedge clk);
    req_valid = '0;
    chk_rsp(tag, c, rd, st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 idle after reset
    chk_bits("R12 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk_bits("R12 grant", {28'b0, req_grant}, 32'h0);
    // R12 no reservation, zero memory
    one_req("R12 sc after reset", 2'd0, SC, 6'd0, 32'h5, 32'h0, 1'b1);
    one_req("R12 mem zero", 2'd0, LD, 6'd0, 32'h0, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      one_req($sformatf("vector %0d", i), VEC[i].core, VEC[i].op, VEC[i].addr,
              VEC[i].wd, VEC[i].rd, VEC[i].st);
    end

    // R11 simultaneous store (core 0) and conditional store (core 1) on one line
    one_req("R11 setup ll", 2'd1, LL, 6'd40, 32'h0, 32'h0, 1'b0);
    @(negedge clk);
    set_req(0, ST, 6'd41, 32'h5);
    set_req(1, SC, 6'd40, 32'h6);
    #1;
    chk_bits("R11 grant low index", {28'b0, req_grant}, 32'h1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    chk_rsp("R11 core0 first", 2'd0, 32'h0, 1'b0);
    #1;
    chk_bits("R11 grant moves", {28'b0, req_grant}, 32'h2);
    @(negedge clk);
    req_valid = '0;
    chk_rsp("R11 R5 core1 sc fails", 2'd1, 32'h0, 1'b1);
    one_req("R5 word unchanged", 2'd2, LD, 6'd40, 32'h0, 32'h0, 1'b0);
    one_req("R11 store landed", 2'd2, LD, 6'd41, 32'h0, 32'h5, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule